// File: doc/BRIEF.md
# Region Memory Attribute Table

This block keeps two attribute flags, cacheable and prefetchable, for each of 256 equal regions of a 32-bit logical address space. Each region spans 16 MB, so the eight most significant address bits pick the region. A cache controller or prefetcher presents a logical address on the lookup port. One clock later it receives that region's two flags.

Software reaches the table through a simple word-addressed register port. Every region has a 32-bit attribute word. Only two bit positions in that word hold state: bit 0 is cacheable and bit 3 is prefetchable. Every other bit reads back as zero, whatever was written to it.

The lowest sixteen regions describe memory inside the core. Their words are fixed at zero and cannot be changed. Writes to them are still accepted and acknowledged, with no error. Reset clears every attribute bit.

Top module: `mem_attr_table`

## Requirements
- R1: The lookup port selects the region from lk_addr[31:24], so region n covers logical addresses n*16 MB up to (n+1)*16 MB - 1.
- R2: A lookup presented with lk_valid high is answered one clock later. In that cycle lk_out_valid is high, lk_cacheable equals bit 0 of the region's word and lk_prefetchable equals bit 3.
- R3: A write to a writable region stores cfg_wdata bit 0 as cacheable and bit 3 as prefetchable. A read returns those two bits in the same positions, and all other bits read as zero, even after a write of all ones.
- R4: Regions 0 to 15 are read-only. A write to one of them is acknowledged, but its word still reads as zero and lookups in that region return both flags low.
- R5: While reset is high, cfg_ack and lk_out_valid are low. After reset, every region reads zero and every lookup returns both flags low.
- R6: The register port is word addressed: region n sits at byte offset 4*n of cfg_addr, and cfg_addr[1:0] is ignored.
- R7: Every register access (cfg_valid high) gets cfg_ack high exactly one clock later. A cycle without an access gives cfg_ack low one clock later. For a read, cfg_rdata is valid in the ack cycle.
- R8: A lookup issued in the same cycle as a write to its region returns the value the region held before that write. A lookup in the next cycle returns the new value.
- R9: A write changes only the region it addresses. All other regions keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Register access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 10 | Byte offset of the attribute word |
| cfg_wdata | input | 32 | Write data |
| cfg_ack | output | 1 | Access acknowledge, one clock after the request |
| cfg_rdata | output | 32 | Read data, valid with cfg_ack |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address to classify |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_cacheable | output | 1 | Region may be cached |
| lk_prefetchable | output | 1 | Region may be prefetched |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it: the register acknowledge and read data, and the lookup flags. A write becomes visible to a lookup presented one cycle after the write. The driver applies inputs on the falling edge and queues one expected record per driven cycle. The monitor samples one nanosecond after the next rising edge and compares exactly one record. An acknowledge or lookup result that comes early, late or not at all therefore shows up as a mismatch. The same-cycle write-and-lookup case is queued with the value held before the write, followed by a second lookup that expects the new value.

// File: rtl/mat_pkg.sv
package mat_pkg;

    localparam int WORD_W   = 32;
    localparam int CACHE_POS = 0;
    localparam int PREF_POS  = 3;
    localparam logic [WORD_W-1:0] LIVE_MASK = (WORD_W'(1) << CACHE_POS) | (WORD_W'(1) << PREF_POS);

    typedef struct packed {
        logic pref;
        logic cache;
    } attr_t;

    function automatic logic [WORD_W-1:0] attr_to_word(attr_t a);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CACHE_POS] = a.cache;
        w[PREF_POS]  = a.pref;
        return w;
    endfunction

    function automatic attr_t word_to_attr(logic [WORD_W-1:0] w);
        attr_t a;
        a.cache = w[CACHE_POS];
        a.pref  = w[PREF_POS];
        return a;
    endfunction

endpackage

// File: rtl/mat_store.sv
module mat_store
    import mat_pkg::*;
#(
    parameter int NUM_REGIONS = 256,
    parameter int RO_REGIONS  = 16,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  attr_t            wr_attr,
    input  logic [IDX_W-1:0] rd_idx_a,
    output attr_t            rd_attr_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output attr_t            rd_attr_b
);

    attr_t entry [NUM_REGIONS];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_ent
        if (g < RO_REGIONS) begin : g_fixed
            assign entry[g] = '0;
        end else begin : g_live
            attr_t q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    q <= wr_attr;
            end
            assign entry[g] = q;
        end
    end

    assign rd_attr_a = entry[rd_idx_a];
    assign rd_attr_b = entry[rd_idx_b];

    // R3: a write to a writable region is held the next cycle
    assert_write_stored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_idx) >= RO_REGIONS) |=> (entry[$past(wr_idx)] == $past(wr_attr)));

endmodule

// File: rtl/mat_regport.sv
module mat_regport
    import mat_pkg::*;
#(
    parameter int NUM_REGIONS = 256,
    parameter int RO_REGIONS  = 16,
    localparam int IDX_W      = $clog2(NUM_REGIONS),
    localparam int CFG_AW     = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  acc_idx,
    output attr_t             wr_attr,
    input  attr_t             rd_attr
);

    logic unused_byte_lane;
    assign unused_byte_lane = ^cfg_addr[1:0];

    assign acc_idx = cfg_addr[CFG_AW-1:2];
    assign wr_en   = cfg_valid && cfg_write;
    assign wr_attr = word_to_attr(cfg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_ack   <= 1'b0;
            cfg_rdata <= '0;
        end else begin
            cfg_ack   <= cfg_valid;
            cfg_rdata <= (cfg_valid && !cfg_write) ? attr_to_word(rd_attr) : '0;
        end
    end

    // R7: acknowledge follows each request by one cycle
    assert_ack_follows_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_valid |=> cfg_ack);
    assert_no_spurious_ack_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |=> !cfg_ack);
    // R3: reserved bits never read as one
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_ack |-> ((cfg_rdata & ~LIVE_MASK) == '0));
    // R4: a read-only region reads zero
    assert_ro_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !cfg_write && int'(acc_idx) < RO_REGIONS) |=> (cfg_rdata == '0));

endmodule

// File: rtl/mat_lookup.sv
module mat_lookup
    import mat_pkg::*;
#(
    parameter int NUM_REGIONS = 256,
    parameter int RO_REGIONS  = 16,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [IDX_W-1:0] rd_idx,
    input  attr_t            rd_attr,
    output logic             lk_out_valid,
    output logic             lk_cacheable,
    output logic             lk_prefetchable
);

    assign rd_idx = lk_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_out_valid    <= 1'b0;
            lk_cacheable    <= 1'b0;
            lk_prefetchable <= 1'b0;
        end else begin
            lk_out_valid    <= lk_valid;
            lk_cacheable    <= lk_valid && rd_attr.cache;
            lk_prefetchable <= lk_valid && rd_attr.pref;
        end
    end

    // R2: result one cycle after the request
    assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> lk_out_valid);
    // R4: internal regions never report cacheable or prefetchable
    assert_ro_lookup_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && int'(lk_idx) < RO_REGIONS) |=> (!lk_cacheable && !lk_prefetchable));

endmodule

// File: rtl/mem_attr_table.sv
module mem_attr_table
    import mat_pkg::*;
#(
    parameter int NUM_REGIONS = 256,
    parameter int RO_REGIONS  = 16,
    parameter int LA_W        = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS),
    localparam int CFG_AW     = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              lk_valid,
    input  logic [LA_W-1:0]   lk_addr,
    output logic              lk_out_valid,
    output logic              lk_cacheable,
    output logic              lk_prefetchable
);

    logic             wr_en;
    logic [IDX_W-1:0] acc_idx;
    logic [IDX_W-1:0] lk_rd_idx;
    attr_t            wr_attr;
    attr_t            cfg_rd_attr;
    attr_t            lk_rd_attr;
    logic             unused_offset;

    assign unused_offset = ^lk_addr[LA_W-IDX_W-1:0];

    mat_regport #(.NUM_REGIONS(NUM_REGIONS), .RO_REGIONS(RO_REGIONS)) u_regport (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .wr_en(wr_en), .acc_idx(acc_idx), .wr_attr(wr_attr), .rd_attr(cfg_rd_attr)
    );

    mat_store #(.NUM_REGIONS(NUM_REGIONS), .RO_REGIONS(RO_REGIONS)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(acc_idx), .wr_attr(wr_attr),
        .rd_idx_a(acc_idx), .rd_attr_a(cfg_rd_attr),
        .rd_idx_b(lk_rd_idx), .rd_attr_b(lk_rd_attr)
    );

    mat_lookup #(.NUM_REGIONS(NUM_REGIONS), .RO_REGIONS(RO_REGIONS)) u_lookup (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_idx(lk_addr[LA_W-1 -: IDX_W]),
        .rd_idx(lk_rd_idx), .rd_attr(lk_rd_attr),
        .lk_out_valid(lk_out_valid), .lk_cacheable(lk_cacheable),
        .lk_prefetchable(lk_prefetchable)
    );

    // R5: outputs are quiet in the cycle after reset
    assert_reset_quiet_R5: assert property (@(posedge clk)
        rst |=> (!cfg_ack && !lk_out_valid && !lk_cacheable && !lk_prefetchable));

endmodule

// File: tb/mem_attr_table_test.sv
module mem_attr_table_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ack;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_out_valid;
    logic        lk_cacheable;
    logic        lk_prefetchable;

    always #2 clk = ~clk;

    mem_attr_table uut (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_out_valid(lk_out_valid), .lk_cacheable(lk_cacheable),
        .lk_prefetchable(lk_prefetchable)
    );

    typedef struct {
        logic        ack;
        logic        rd;
        logic [31:0] data;
        logic        lv;
        logic        c;
        logic        p;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [1:0] model [256];   // [0] cacheable, [1] prefetchable
    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 256; i++) model[i] = 2'b00;
    endtask

    task automatic drive(input logic cv, input logic cw, input logic [9:0] ca, input logic [31:0] cd,
                         input logic lv, input logic [31:0] la, input string tag);
        exp_t e;
        int ci;
        int li;
        @(negedge clk);
        cfg_valid = cv; cfg_write = cw; cfg_addr = ca; cfg_wdata = cd;
        lk_valid = lv; lk_addr = la;
        ci = int'(ca[9:2]);
        li = int'(la[31:24]);
        e.ack  = cv;
        e.rd   = cv && !cw;
        e.data = {28'b0, model[ci][1], 2'b00, model[ci][0]};
        e.lv   = lv;
        e.c    = lv && model[li][0];
        e.p    = lv && model[li][1];
        e.tag  = tag;
        sb.push_back(e);
        if (cv && cw && ci >= 16) model[ci] = {cd[3], cd[0]};
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input string tag);
        drive(1'b1, 1'b1, 10'(idx * 4), d, 1'b0, 32'h0, tag);
    endtask

    task automatic rd(input logic [9:0] a, input string tag);
        drive(1'b1, 1'b0, a, 32'h0, 1'b0, 32'h0, tag);
    endtask

    task automatic lk(input logic [31:0] a, input string tag);
        drive(1'b0, 1'b0, 10'h0, 32'h0, 1'b1, a, tag);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 10'h0, 32'h0, 1'b0, 32'h0, "idle");
    endtask

    // monitor: one expected record per driven cycle, compared after the next rising edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            chk(cfg_ack === e.ack, {"R7 ack ", e.tag}, 32'(cfg_ack), 32'(e.ack));
            if (e.rd)
                chk(cfg_rdata === e.data, {"read ", e.tag}, cfg_rdata, e.data);
            chk(lk_out_valid === e.lv, {"R2 lookup valid ", e.tag}, 32'(lk_out_valid), 32'(e.lv));
            if (e.lv) begin
                chk(lk_cacheable === e.c, {"cacheable ", e.tag}, 32'(lk_cacheable), 32'(e.c));
                chk(lk_prefetchable === e.p, {"prefetchable ", e.tag}, 32'(lk_prefetchable), 32'(e.p));
            end
        end
    end

    task automatic reset_phase();
        @(negedge clk);
        rst = 1'b1;
        cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = 10'h40;
        lk_valid = 1'b1; lk_addr = 32'h1000_0000;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk(!cfg_ack && !lk_out_valid && !lk_cacheable && !lk_prefetchable,
                "R5 outputs low in reset", {30'b0, cfg_ack, lk_out_valid}, 32'h0);
        end
        @(negedge clk);
        rst = 1'b0;
        cfg_valid = 1'b0; lk_valid = 1'b0;
        model_clear();
    endtask

    initial begin
        model_clear();
        reset_phase();

        // R5: everything zero after reset
        for (int i = 0; i < 256; i++)
            drive(1'b1, 1'b0, 10'(i * 4), 32'h0, 1'b1, {8'(i), 24'h00_0123}, "R5 post-reset");

        // R3 / R4 / R6 writes
        wr(16, 32'hFFFF_FFFF, "R3 all-ones write");
        wr(255, 32'h0000_0001, "R3 cache only");
        wr(128, 32'h0000_0008, "R3 prefetch only");
        wr(40, 32'h0000_0009, "R3 both");
        wr(5, 32'h0000_000F, "R4 write to internal");
        wr(0, 32'h0000_0009, "R4 write to region 0");
        wr(15, 32'h0000_0009, "R4 write to region 15");
        drive(1'b1, 1'b1, 10'(20 * 4 + 3), 32'h0000_0009, 1'b0, 32'h0, "R6 unaligned write");

        rd(10'(16 * 4), "R3 reserved bits read zero");
        rd(10'(5 * 4), "R4 region 5 reads zero");
        rd(10'(0), "R4 region 0 reads zero");
        rd(10'(15 * 4), "R4 region 15 reads zero");
        rd(10'(20 * 4), "R6 aligned read");
        rd(10'(20 * 4 + 1), "R6 offset 1 read");
        rd(10'(128 * 4 + 2), "R6 offset 2 read");

        // R1 / R2 lookups
        lk(32'h8000_0000, "R1 region 128 base");
        lk(32'hFFFF_FFFF, "R1 top address");
        lk(32'h2812_3456, "R1 region 40 middle");
        lk(32'h0FFF_FFFF, "R1 R4 last internal byte");
        lk(32'h1000_0000, "R1 first writable byte");
        lk(32'h0500_0000, "R4 lookup region 5");
        lk(32'h14FF_FFFF, "R1 region 20 end");
        lk(32'h7FFF_FFFF, "R1 region 127 untouched");

        // R8: same-cycle write and lookup
        drive(1'b1, 1'b1, 10'(50 * 4), 32'h0000_0001, 1'b1, 32'h3200_0000, "R8 old value");
        lk(32'h3200_00FF, "R8 new value");

        // back-to-back lookups and a read overlapping
        drive(1'b1, 1'b0, 10'(40 * 4), 32'h0, 1'b1, 32'h80AB_CDEF, "R2 overlapping read and lookup");

        // R3 clear
        wr(16, 32'h0000_0000, "R3 clear");
        rd(10'(16 * 4), "R3 cleared reads zero");

        // R9: no other region disturbed
        for (int i = 0; i < 256; i++)
            drive(1'b1, 1'b0, 10'(i * 4), 32'h0, 1'b1, {8'(255 - i), 24'hAB_CDEF}, "R9 full sweep");

        idle();
        idle();
        wait (sb.size() == 0);

        // R5: reset again clears written state
        reset_phase();
        rd(10'(40 * 4), "R5 region 40 cleared");
        rd(10'(255 * 4), "R5 region 255 cleared");
        lk(32'h8000_0000, "R5 lookup region 128 cleared");
        lk(32'h3200_0000, "R5 lookup region 50 cleared");
        idle();
        idle();
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule